// File: doc/BRIEF.md
# Host Command and Result Sequencer

This block carries the byte-wide conversation between a host processor and a disk controller core. The host writes a command as an opcode byte followed by parameter bytes. The core then executes the command, and the host reads back the result bytes. The host paces every byte by polling a status byte. The status byte is always readable, and it reports whether the data port is ready, which way the next byte moves, whether the core is executing, and whether a command is in progress. The address bit `a0_i` chooses between the status byte (low) and the data port (high).

The sequencer decodes the low five bits of the opcode against a small table. The table gives the number of parameter bytes, the number of result bytes, and whether completion raises an interrupt. Parameter bytes are handed to the execution unit one at a time, each with its index. The execution unit receives a start pulse and later answers with a done strobe. While the result phase runs, it supplies each result byte on demand by index. An opcode that is not in the table skips execution and produces a single result byte of 0x80.

Top module: `hsq_host_seq`

## Requirements
- R1: Reading with `a0_i`=0 returns the status byte at any time: bit 7 ready, bit 6 direction (1 = toward host), bit 5 executing, bit 4 busy, bits 3:0 zero. After reset it reads 0x80 and `irq_o` is low.
- R2: The low five bits of the opcode select the command and the upper three bits are ignored. Parameter/result counts are: 0x06 8/7, 0x05 8/7, 0x0A 1/7, 0x0D 5/7, 0x07 1/0, 0x0F 2/0, 0x08 0/2, 0x03 2/0, 0x04 1/1. `exec_op_o` carries the five-bit code.
- R3: In the cycle after any accepted data byte the ready bit is low. It returns high one cycle later unless the sequencer has moved to execution or idle-with-hold.
- R4: During the parameter phase the status byte reads 0x90 when ready. Each accepted parameter byte pulses `prm_we_o` with its zero-based index on `prm_idx_o` and the byte on `prm_data_o`. The opcode byte never pulses `prm_we_o`.
- R5: Accepting the last command byte enters execution, where the status byte reads 0x30. `exec_start_o` is high for exactly one cycle, in the cycle after that acceptance.
- R6: A done strobe during execution leads to one of two states. If the command has result bytes, the result phase begins (status 0xD0), and data reads return `res_data_i` for indices 0, 1, … in order on `res_idx_o`. If it has none, the sequencer returns to idle (status 0x80). After the last result byte the status byte reads 0x00 for one cycle, then 0x80.
- R7: `irq_o` rises on the done strobe for codes 0x06, 0x05, 0x0A, 0x0D, 0x07 and 0x0F, and stays low for 0x08, 0x03 and 0x04. It is cleared by the first accepted result read or, for commands without results, by the next accepted opcode write.
- R8: An opcode outside the table enters the result phase directly (status 0x50, then 0xD0) without `exec_start_o` and without an interrupt. It yields exactly one result byte, 0x80.
- R9: A data write while the direction bit is 1 or during execution, and a data read while the direction bit is 0, are ignored. They advance no index, pulse no strobe and leave the status byte unchanged. A data read outside the result phase returns 0x00.
- R10: Result bytes pass through unchanged, including an abnormal-termination first byte whose bits 7:6 are 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select, qualifies strobes |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| a0_i | input | 1 | 0 = status byte, 1 = data port |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data |
| irq_o | output | 1 | Interrupt request |
| exec_start_o | output | 1 | One-cycle execution start |
| exec_op_o | output | 5 | Decoded command code |
| prm_we_o | output | 1 | Parameter byte valid |
| prm_idx_o | output | 4 | Parameter index |
| prm_data_o | output | 8 | Parameter byte |
| exec_done_i | input | 1 | Execution finished strobe |
| res_idx_o | output | 4 | Index of requested result byte |
| res_data_i | input | 8 | Result byte from execution unit |

## Verification
Two events can fall in the same cycle: the done strobe that ends execution, and a host write to the data port that the host fires blind, without polling. The bench provokes this by raising `exec_done_i` and a data-port write in the same cycle for chosen commands. It then requires that `prm_we_o` stays low, that the status byte moves to 0xD0 or 0x80 as the command dictates, and that the first result byte still comes from index 0. Illegal-direction accesses are also mixed between legal bytes at random. Each must leave the status byte and the indices untouched.

// File: rtl/hsq_pkg.sv
package hsq_pkg;
  localparam int DATA_W = 8;
  localparam int OP_W   = 5;
  localparam int CNT_W  = 4;
  localparam logic [DATA_W-1:0] INV_RES = 8'h80;

  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;

  typedef struct packed {
    logic             valid;
    logic [CNT_W-1:0] n_prm;
    logic [CNT_W-1:0] n_res;
    logic             irq_done;
  } cmd_info_t;
endpackage

// File: rtl/hsq_cmd_table.sv
module hsq_cmd_table
  import hsq_pkg::*;
(
  input  logic [OP_W-1:0] code_i,
  output cmd_info_t       info_o
);
  function automatic cmd_info_t ent(input logic v, input int p, input int r, input logic q);
    cmd_info_t e;
    e.valid    = v;
    e.n_prm    = CNT_W'(p);
    e.n_res    = CNT_W'(r);
    e.irq_done = q;
    return e;
  endfunction

  always_comb begin
    unique case (code_i)
      5'h06:   info_o = ent(1'b1, 8, 7, 1'b1);
      5'h05:   info_o = ent(1'b1, 8, 7, 1'b1);
      5'h0A:   info_o = ent(1'b1, 1, 7, 1'b1);
      5'h0D:   info_o = ent(1'b1, 5, 7, 1'b1);
      5'h07:   info_o = ent(1'b1, 1, 0, 1'b1);
      5'h0F:   info_o = ent(1'b1, 2, 0, 1'b1);
      5'h08:   info_o = ent(1'b1, 0, 2, 1'b0);
      5'h03:   info_o = ent(1'b1, 2, 0, 1'b0);
      5'h04:   info_o = ent(1'b1, 1, 1, 1'b0);
      default: info_o = ent(1'b0, 0, 1, 1'b0); // invalid: one fixed result byte
    endcase
  end
endmodule

// File: rtl/hsq_phase_ctrl.sv
module hsq_phase_ctrl
  import hsq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              exec_done_i,
  input  cmd_info_t         info_i,
  output logic [OP_W-1:0]   tbl_code_o,
  output phase_e            phase_o,
  output logic              hold_o,
  output logic              inv_o,
  output logic              wr_acc_o,
  output logic              rd_acc_o,
  output logic              irq_o,
  output logic              start_o,
  output logic [OP_W-1:0]   op_o,
  output logic [CNT_W-1:0]  cnt_o
);
  phase_e            phase_q, phase_d;
  logic [OP_W-1:0]   op_q, op_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              hold_q, inv_q, inv_d, start_q, start_d, irq_q, irq_d;
  logic              port_wr, port_rd;

  assign port_wr    = cs_i & wr_i & a0_i & ~hold_q;
  assign port_rd    = cs_i & rd_i & a0_i & ~hold_q;
  assign wr_acc_o   = port_wr & ((phase_q == PH_IDLE) | (phase_q == PH_CMD));
  assign rd_acc_o   = port_rd & (phase_q == PH_RES);
  // decode the incoming opcode while idle, the latched one afterwards
  assign tbl_code_o = (phase_q == PH_IDLE) ? wdata_i[OP_W-1:0] : op_q;

  always_comb begin
    phase_d = phase_q;
    op_d    = op_q;
    cnt_d   = cnt_q;
    inv_d   = inv_q;
    irq_d   = irq_q;
    start_d = 1'b0;
    unique case (phase_q)
      PH_IDLE: if (wr_acc_o) begin
        op_d  = wdata_i[OP_W-1:0];
        cnt_d = '0;
        irq_d = 1'b0;
        if (!info_i.valid) begin
          inv_d   = 1'b1;
          phase_d = PH_RES;
        end else if (info_i.n_prm == '0) begin
          phase_d = PH_EXEC;
          start_d = 1'b1;
        end else begin
          phase_d = PH_CMD;
        end
      end
      PH_CMD: if (wr_acc_o) begin
        if (cnt_q == info_i.n_prm - 1'b1) begin
          cnt_d   = '0;
          phase_d = PH_EXEC;
          start_d = 1'b1;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      PH_EXEC: if (exec_done_i) begin
        cnt_d   = '0;
        irq_d   = info_i.irq_done;
        phase_d = (info_i.n_res == '0) ? PH_IDLE : PH_RES;
      end
      PH_RES: if (rd_acc_o) begin
        irq_d = 1'b0;
        if (cnt_q == info_i.n_res - 1'b1) begin
          cnt_d   = '0;
          inv_d   = 1'b0;
          phase_d = PH_IDLE;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      op_q    <= '0;
      cnt_q   <= '0;
      hold_q  <= 1'b0;
      inv_q   <= 1'b0;
      start_q <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      op_q    <= op_d;
      cnt_q   <= cnt_d;
      hold_q  <= wr_acc_o | rd_acc_o;
      inv_q   <= inv_d;
      start_q <= start_d;
      irq_q   <= irq_d;
    end
  end

  assign phase_o = phase_q;
  assign hold_o  = hold_q;
  assign inv_o   = inv_q;
  assign irq_o   = irq_q;
  assign start_o = start_q;
  assign op_o    = op_q;
  assign cnt_o   = cnt_q;
endmodule

// File: rtl/hsq_status.sv
module hsq_status
  import hsq_pkg::*;
#(
  parameter int RSV_BITS = 4
) (
  input  phase_e            phase_i,
  input  logic              hold_i,
  input  logic              inv_i,
  input  logic              a0_i,
  input  logic [DATA_W-1:0] res_data_i,
  output logic [DATA_W-1:0] msr_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic rqm, dio, exm, cb;
  logic [DATA_W-1:0] data_rd;

  assign rqm = (phase_i != PH_EXEC) & ~hold_i;
  assign dio = (phase_i == PH_RES);
  assign exm = (phase_i == PH_EXEC);
  assign cb  = (phase_i != PH_IDLE);

  assign msr_o[7:4] = {rqm, dio, exm, cb};
  for (genvar b = 0; b < RSV_BITS; b++) begin : g_rsv
    assign msr_o[b] = 1'b0;
  end

  assign data_rd = !dio ? '0 : (inv_i ? INV_RES : res_data_i);
  assign rdata_o = a0_i ? data_rd : msr_o;
endmodule

// File: rtl/hsq_host_seq.sv
module hsq_host_seq
  import hsq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_i,
  input  logic        rd_i,
  input  logic        wr_i,
  input  logic        a0_i,
  input  logic [7:0]  wdata_i,
  output logic [7:0]  rdata_o,
  output logic        irq_o,
  output logic        exec_start_o,
  output logic [4:0]  exec_op_o,
  output logic        prm_we_o,
  output logic [3:0]  prm_idx_o,
  output logic [7:0]  prm_data_o,
  input  logic        exec_done_i,
  output logic [3:0]  res_idx_o,
  input  logic [7:0]  res_data_i
);
  cmd_info_t        info_w;
  phase_e           phase_w;
  logic [OP_W-1:0]  code_w, op_w;
  logic [CNT_W-1:0] cnt_w;
  logic             hold_w, inv_w, wr_acc_w, rd_acc_w;
  logic [7:0]       msr_w;

  hsq_cmd_table u_tbl (
    .code_i (code_w),
    .info_o (info_w)
  );

  hsq_phase_ctrl u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_i        (cs_i),
    .rd_i        (rd_i),
    .wr_i        (wr_i),
    .a0_i        (a0_i),
    .wdata_i     (wdata_i),
    .exec_done_i (exec_done_i),
    .info_i      (info_w),
    .tbl_code_o  (code_w),
    .phase_o     (phase_w),
    .hold_o      (hold_w),
    .inv_o       (inv_w),
    .wr_acc_o    (wr_acc_w),
    .rd_acc_o    (rd_acc_w),
    .irq_o       (irq_o),
    .start_o     (exec_start_o),
    .op_o        (op_w),
    .cnt_o       (cnt_w)
  );

  hsq_status #(.RSV_BITS(4)) u_stat (
    .phase_i    (phase_w),
    .hold_i     (hold_w),
    .inv_i      (inv_w),
    .a0_i       (a0_i),
    .res_data_i (res_data_i),
    .msr_o      (msr_w),
    .rdata_o    (rdata_o)
  );

  assign exec_op_o  = op_w;
  assign prm_we_o   = wr_acc_w & (phase_w == PH_CMD);
  assign prm_idx_o  = cnt_w;
  assign prm_data_o = wdata_i;
  assign res_idx_o  = cnt_w;
endmodule

// File: rtl/hsq_host_seq_chk.sv
module hsq_host_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       irq_o,
  input logic       exec_start_o,
  input logic       exec_done_i,
  input logic [7:0] msr_w,
  input logic       wr_acc_w,
  input logic       rd_acc_w
);
  // R3
  wr_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_acc_w |=> !msr_w[7]);
  // R3
  rd_rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) rd_acc_w |=> !msr_w[7]);
  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $rose(irq_o) |-> $past(exec_done_i));
  // R7
  irq_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) (rd_acc_w && irq_o) |=> !irq_o);
  // R5
  start_exec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_start_o |-> (msr_w[5] && !msr_w[7] && !msr_w[6]));
  // R9
  wr_dir_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) wr_acc_w |-> !msr_w[6]);
  // R1
  rsv_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) msr_w[3:0] == 4'h0);
  // R6
  res_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) msr_w[6] |-> msr_w[4]);
endmodule

bind hsq_host_seq hsq_host_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_o        (irq_o),
  .exec_start_o (exec_start_o),
  .exec_done_i  (exec_done_i),
  .msr_w        (msr_w),
  .wr_acc_w     (wr_acc_w),
  .rd_acc_w     (rd_acc_w)
);

// File: tb/hsq_host_seq_tb_top.sv
`timescale 1ns/1ps
module hsq_host_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       cs_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, a0_i = 1'b0;
  logic [7:0] wdata_i = '0;
  logic [7:0] rdata_o;
  logic       irq_o, exec_start_o, prm_we_o, exec_done_i = 1'b0;
  logic [4:0] exec_op_o;
  logic [3:0] prm_idx_o, res_idx_o;
  logic [7:0] prm_data_o, res_data_i;

  int  n_chk = 0, n_bad = 0, start_cnt = 0;
  bit  finished = 1'b0, pend_irq = 1'b0;
  logic [7:0] cur_op = '0;
  bit  cur_abn = 1'b0;

  always #5 clk = ~clk;

  hsq_host_seq dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .cs_i(cs_i), .rd_i(rd_i), .wr_i(wr_i), .a0_i(a0_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .exec_start_o(exec_start_o),
    .exec_op_o(exec_op_o), .prm_we_o(prm_we_o), .prm_idx_o(prm_idx_o),
    .prm_data_o(prm_data_o), .exec_done_i(exec_done_i), .res_idx_o(res_idx_o),
    .res_data_i(res_data_i)
  );

  function automatic logic [7:0] res_model(input logic [7:0] op, input logic [3:0] idx, input bit abn);
    if (abn && idx == 4'd0) return 8'h41;
    return {op[3:0], idx} ^ 8'h5A;
  endfunction
  assign res_data_i = res_model(cur_op, res_idx_o, cur_abn);

  // R2 expected table
  function automatic int t_nprm(input logic [4:0] c);
    case (c)
      5'h06, 5'h05: return 8;
      5'h0D: return 5;
      5'h0F, 5'h03: return 2;
      5'h0A, 5'h07, 5'h04: return 1;
      default: return 0;
    endcase
  endfunction
  function automatic int t_nres(input logic [4:0] c);
    case (c)
      5'h06, 5'h05, 5'h0A, 5'h0D: return 7;
      5'h08: return 2;
      5'h07, 5'h0F, 5'h03: return 0;
      default: return 1;
    endcase
  endfunction
  function automatic bit t_valid(input logic [4:0] c);
    case (c)
      5'h06, 5'h05, 5'h0A, 5'h0D, 5'h07, 5'h0F, 5'h08, 5'h03, 5'h04: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction
  function automatic bit t_irq(input logic [4:0] c);
    case (c)
      5'h06, 5'h05, 5'h0A, 5'h0D, 5'h07, 5'h0F: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) if (exec_start_o) start_cnt <= start_cnt + 1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic msr_now(output logic [7:0] m);
    a0_i = 1'b0;
    #1 m = rdata_o;
  endtask

  task automatic wr_byte(input logic [7:0] d, output logic we, output logic [3:0] idx, output logic [7:0] pd);
    @(negedge clk);
    cs_i = 1'b1; wr_i = 1'b1; a0_i = 1'b1; wdata_i = d;
    #1 we = prm_we_o; idx = prm_idx_o; pd = prm_data_o;
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0;
  endtask

  task automatic rd_byte(output logic [7:0] d);
    @(negedge clk);
    cs_i = 1'b1; rd_i = 1'b1; a0_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk);
    cs_i = 1'b0; rd_i = 1'b0;
  endtask

  // ignored access: write (dir_wr=1) or read, status byte must hold exp_msr
  task automatic bad_access(input bit dir_wr, input logic [7:0] exp_msr, input logic [3:0] exp_idx);
    logic [7:0] m, d;
    @(negedge clk);
    cs_i = 1'b1; a0_i = 1'b1; wdata_i = 8'hC3;
    if (dir_wr) wr_i = 1'b1; else rd_i = 1'b1;
    #1 d = rdata_o;
    chk(prm_we_o == 1'b0, "R9 ignored access strobe", prm_we_o, 0);
    if (!dir_wr) chk(d == 8'h00, "R9 read outside result", d, 0);
    @(negedge clk);
    cs_i = 1'b0; wr_i = 1'b0; rd_i = 1'b0;
    msr_now(m);
    chk(m == exp_msr, "R9 status unchanged", m, exp_msr);
    chk(res_idx_o == exp_idx, "R9 index unchanged", res_idx_o, exp_idx);
  endtask

  task automatic run_cmd(input logic [7:0] op, input bit abn, input int dly, input bit bad, input bit collide);
    logic we; logic [3:0] pi; logic [7:0] pd, m, d, pv;
    int np, nr, s0; bit v, ei;
    v = t_valid(op[4:0]); np = t_nprm(op[4:0]); nr = t_nres(op[4:0]); ei = t_irq(op[4:0]);
    cur_op = op; cur_abn = abn; s0 = start_cnt;
    wr_byte(op, we, pi, pd);
    chk(we == 1'b0, "R4 opcode no param strobe", we, 0);
    if (pend_irq) begin
      chk(irq_o == 1'b0, "R7 irq cleared by opcode", irq_o, 0);
      pend_irq = 1'b0;
    end
    msr_now(m);
    if (!v) begin
      chk(m == 8'h50, "R8 invalid to result", m, 8'h50);
      @(negedge clk); msr_now(m);
      chk(m == 8'hD0, "R8 result ready", m, 8'hD0);
      chk(irq_o == 1'b0, "R8 no irq", irq_o, 0);
      if (bad) bad_access(1'b1, 8'hD0, 4'd0);
      rd_byte(d);
      chk(d == 8'h80, "R8 invalid result byte", d, 8'h80);
      chk(start_cnt == s0, "R8 no exec start", start_cnt, s0);
      msr_now(m);
      chk(m == 8'h00, "R3 hold after last", m, 0);
      @(negedge clk); msr_now(m);
      chk(m == 8'h80, "R6 back to idle", m, 8'h80);
      return;
    end
    if (np > 0) chk(m == 8'h10, "R3 hold after opcode", m, 8'h10);
    for (int i = 0; i < np; i++) begin
      if (bad && i == 0) bad_access(1'b0, 8'h90, 4'd0);
      pv = 8'($urandom);
      wr_byte(pv, we, pi, pd);
      chk(we && pi == 4'(i) && pd == pv, "R4 param strobe/index", {we, pi, pd}, {1'b1, 4'(i), pv});
      if (i < np - 1) begin
        msr_now(m);
        chk(m == 8'h10, "R3 hold after param", m, 8'h10);
      end
    end
    msr_now(m);
    chk(m == 8'h30, "R5 execution status", m, 8'h30);
    chk(exec_start_o == 1'b1, "R5 start pulse", exec_start_o, 1);
    chk(exec_op_o == op[4:0], "R2 code ignores upper bits", exec_op_o, op[4:0]);
    @(negedge clk);
    chk(exec_start_o == 1'b0, "R5 start one cycle", exec_start_o, 0);
    chk(start_cnt == s0 + 1, "R5 single start", start_cnt, s0 + 1);
    if (bad) bad_access(1'b1, 8'h30, 4'd0);
    repeat (dly) @(negedge clk);
    @(negedge clk);
    exec_done_i = 1'b1;
    if (collide) begin cs_i = 1'b1; wr_i = 1'b1; a0_i = 1'b1; wdata_i = 8'hEE; end
    #1 chk(prm_we_o == 1'b0, "R9 write at done ignored", prm_we_o, 0);
    @(negedge clk);
    exec_done_i = 1'b0; cs_i = 1'b0; wr_i = 1'b0;
    msr_now(m);
    chk(m == (nr > 0 ? 8'hD0 : 8'h80), "R6 status after done", m, (nr > 0 ? 8'hD0 : 8'h80));
    chk(irq_o == ei, "R7 irq on done", irq_o, ei);
    if (nr == 0) begin pend_irq = ei; return; end
    for (int j = 0; j < nr; j++) begin
      if (bad && j == 1) bad_access(1'b1, 8'hD0, 4'(j));
      chk(res_idx_o == 4'(j), "R6 result index", res_idx_o, j);
      rd_byte(d);
      chk(d == res_model(op, 4'(j), abn), "R10 result byte", d, res_model(op, 4'(j), abn));
      if (j == 0) chk(irq_o == 1'b0, "R7 irq cleared on first read", irq_o, 0);
      msr_now(m);
      chk(m == (j < nr - 1 ? 8'h50 : 8'h00), "R3 hold after read", m, (j < nr - 1 ? 8'h50 : 8'h00));
    end
    @(negedge clk); msr_now(m);
    chk(m == 8'h80, "R6 idle after results", m, 8'h80);
  endtask

  initial begin
    logic [7:0] m, d;
    logic [7:0] vlist [9] = '{8'h06, 8'h05, 8'h0A, 8'h0D, 8'h07, 8'h0F, 8'h08, 8'h03, 8'h04};
    logic [7:0] op;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    msr_now(m);
    chk(m == 8'h80, "R1 status in reset", m, 8'h80);
    rst_ni = 1'b1;
    @(negedge clk); msr_now(m);
    chk(m == 8'h80, "R1 status after reset", m, 8'h80);
    chk(irq_o == 1'b0, "R1 irq after reset", irq_o, 0);
    @(negedge clk); cs_i = 1'b1; rd_i = 1'b1; a0_i = 1'b1; #1 d = rdata_o;
    chk(d == 8'h00, "R9 idle data read", d, 0);
    @(negedge clk); cs_i = 1'b0; rd_i = 1'b0; msr_now(m);
    chk(m == 8'h80, "R9 idle read ignored", m, 8'h80);
    // directed corners
    run_cmd(8'h00, 1'b0, 0, 1'b1, 1'b0);   // R8
    run_cmd(8'hFF, 1'b0, 0, 1'b0, 1'b0);   // R8 with upper bits
    run_cmd(8'hE8, 1'b0, 0, 1'b1, 1'b0);   // R2 sense-type, no params
    run_cmd(8'h46, 1'b1, 2, 1'b1, 1'b1);   // R10 abnormal, collision
    run_cmd(8'h0F, 1'b0, 1, 1'b0, 1'b1);   // R7 irq without results
    run_cmd(8'h03, 1'b0, 0, 1'b0, 1'b0);   // R7 cleared by next opcode
    run_cmd(8'h04, 1'b0, 3, 1'b1, 1'b0);
    for (int k = 0; k < 60; k++) begin
      int r = int'($urandom % 12);
      if (r < 9) op = {3'($urandom), vlist[r][4:0]};
      else op = {3'($urandom), 5'(r == 9 ? 5'h11 : (r == 10 ? 5'h1F : 5'h02))};
      run_cmd(op, 1'($urandom), int'($urandom % 6), 1'($urandom), 1'($urandom));
    end
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual 0x0 expected 0x1");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule